// File: doc/BRIEF.md
# Serial Flash Sector Lock Register

This block is the slave-side command logic that guards the sectors of a 16 Mbit serial flash. Each of the 32 sectors owns a lock byte. Only the two low bits of that byte are real. Bit 0 is the write-lock bit, and the block exports it as a per-sector write-inhibit line for the program/erase engine. Bit 1 is the lock-down bit. Once it is set, the whole byte is frozen until the next reset.

A host reaches the lock bytes over a four-wire serial port. The wires are an active-low select, a serial clock, a data input and a data output with its own output enable. Two commands are decoded. A read command returns the lock byte of the addressed sector. A write command updates it, but only when the write-enable latch is set and the byte arrives complete. Both commands are ignored while the program/erase engine reports busy.

The pins are oversampled by the system clock. The serial clock must therefore run at no more than a quarter of the system clock, and its edges are detected synchronously.

Top module: `spi_lock_reg`

## Requirements
- R1: After reset every lock byte reads 0x00, every write-inhibit line is 0, and the data output enable is 0.
- R2: A command starts with chip select low. The first 8 bits form the opcode and the next 24 bits form the address. All are taken MSB first on rising serial clock edges. Address bits 20..16 pick the sector, and bits 23..21 and 15..0 have no effect.
- R3: Opcode 0xE8 reads a lock byte. After the 32nd rising edge, the byte is driven MSB first, and each bit changes on a falling serial clock edge. After 8 bits the same byte starts again. This works with the clock idling low or high.
- R4: Bits 7..2 of a lock byte always read 0, whatever value was written.
- R5: The data output enable is 1 only while read-data bits are being shifted out. It is 0 through the opcode and address phases, and it returns to 0 in the system clock cycle after chip select rises.
- R6: Opcode 0xE5 is followed by a 24-bit address and one data byte. When chip select rises, data bits 1..0 are stored as the lock-down and write-lock bits. This happens only if exactly 8 data bits were clocked in and the write-enable latch input is 1. Otherwise the byte is unchanged.
- R7: Write-inhibit line s equals bit 0 (write-lock) of sector s.
- R8: While bit 1 (lock-down) of a sector is 1, writes to that sector change neither bit 0 nor bit 1. Only reset clears it.
- R9: A command is dropped without any effect in two cases. The first is when the busy input is 1 as its opcode completes. No data is driven and nothing is written. The second is when busy is 1 as chip select rises at the end of a write.
- R10: After an unknown opcode, all remaining bits are ignored until chip select rises. No data is driven and no write takes place. The next command then decodes normally.
- R11: Chip select may rise at any point of the read-data phase. The next command then decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| write_enable_latch | input | 1 | Write-enable latch state from the command layer |
| pe_busy | input | 1 | Program/erase engine busy |
| sector_wr_inhibit | output | 32 | Per-sector write-inhibit (lock byte bit 0) |

## Verification
The hardest state to reach is a lock-down sector that still faces a write. Getting there needs a complete, enabled, non-busy write carrying bit 1. A second write to the same sector must then follow, and a reset must come after that to show the bit clears. The random stimulus sets bit 1 only rarely, so that most sectors stay writable. It mixes short and long data phases, dropped enables and busy windows, and issues a reset every 50 commands so that locked sectors recur. Directed sequences lock a sector and then try to clear it, try partial bytes, and terminate reads early.

// File: rtl/spi_lock_pkg.sv
package spi_lock_pkg;

    localparam logic [7:0] OP_READ_LOCK  = 8'hE8;
    localparam logic [7:0] OP_WRITE_LOCK = 8'hE5;
    localparam int         OPCODE_BITS   = 8;
    localparam int         DATA_BITS     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_IGNORE
    } cmd_state_e;

endpackage

// File: rtl/spi_pin_edges.sv
module spi_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);

    typedef struct packed {
        logic cs_n;
        logic sck;
    } pins_t;

    pins_t pins_d, pins_q;

    always_comb begin
        pins_d      = pins_q;
        pins_d.cs_n = cs_n;
        pins_d.sck  = sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q.cs_n <= 1'b1;
            pins_q.sck  <= 1'b0;
        end else begin
            pins_q <= pins_d;
        end
    end

    // edges are seen in the cycle the new pin level is first sampled
    assign sck_rise = sck & ~pins_q.sck;
    assign sck_fall = ~sck & pins_q.sck;
    assign cs_rise  = cs_n & ~pins_q.cs_n;

endmodule

// File: rtl/lock_cmd_fsm.sv
module lock_cmd_fsm
    import spi_lock_pkg::*;
#(
    parameter int ADDR_BITS       = 24,
    parameter int SECTOR_ADDR_LSB = 16,
    parameter int SECT_W          = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_rise,
    input  logic              busy,
    input  logic              wel,
    input  logic [7:0]        rd_byte,
    output logic [SECT_W-1:0] rd_sect,
    output logic              wr_en,
    output logic [SECT_W-1:0] wr_sect,
    output logic [1:0]        wr_bits,
    output logic              miso,
    output logic              miso_oe
);

    localparam int CNT_W = $clog2(ADDR_BITS + 1);
    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(OPCODE_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_FULL = CNT_W'(DATA_BITS);
    localparam logic [CNT_W-1:0] DATA_OVER = CNT_W'(DATA_BITS + 1);

    typedef struct packed {
        cmd_state_e           state;
        logic [CNT_W-1:0]     cnt;
        logic [ADDR_BITS-1:0] sh;
        logic [SECT_W-1:0]    sect;
        logic                 is_write;
        logic [2:0]           bidx;
        logic                 miso;
        logic                 oe;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        wr_en = 1'b0;

        if (cs_n) begin
            // a write commits only on a clean 8-bit data phase
            if (cs_rise && fsm_q.state == ST_WDATA && fsm_q.cnt == DATA_FULL
                && wel && !busy) begin
                wr_en = 1'b1;
            end
            fsm_d.state = ST_IDLE;
            fsm_d.cnt   = '0;
            fsm_d.oe    = 1'b0;
        end else begin
            unique case (fsm_q.state)
                ST_IDLE, ST_OPCODE: begin
                    if (sck_rise) begin
                        fsm_d.sh    = {fsm_q.sh[ADDR_BITS-2:0], mosi};
                        fsm_d.cnt   = fsm_q.cnt + 1'b1;
                        fsm_d.state = ST_OPCODE;
                        if (fsm_q.cnt == OPC_LAST) begin
                            fsm_d.cnt = '0;
                            if (busy) begin
                                fsm_d.state = ST_IGNORE;
                            end else if (fsm_d.sh[7:0] == OP_READ_LOCK) begin
                                fsm_d.state    = ST_ADDR;
                                fsm_d.is_write = 1'b0;
                            end else if (fsm_d.sh[7:0] == OP_WRITE_LOCK) begin
                                fsm_d.state    = ST_ADDR;
                                fsm_d.is_write = 1'b1;
                            end else begin
                                fsm_d.state = ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        fsm_d.sh  = {fsm_q.sh[ADDR_BITS-2:0], mosi};
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                        if (fsm_q.cnt == ADDR_LAST) begin
                            fsm_d.sect  = fsm_d.sh[SECTOR_ADDR_LSB +: SECT_W];
                            fsm_d.cnt   = '0;
                            fsm_d.bidx  = '0;
                            fsm_d.state = fsm_q.is_write ? ST_WDATA : ST_RDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (sck_fall) begin
                        fsm_d.miso = rd_byte[3'd7 - fsm_q.bidx];
                        fsm_d.oe   = 1'b1;
                        fsm_d.bidx = fsm_q.bidx + 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (sck_rise) begin
                        fsm_d.sh = {fsm_q.sh[ADDR_BITS-2:0], mosi};
                        if (fsm_q.cnt != DATA_OVER) begin
                            fsm_d.cnt = fsm_q.cnt + 1'b1;
                        end
                    end
                end
                ST_IGNORE: begin
                    fsm_d.oe = 1'b0;
                end
                default: begin
                    fsm_d.state = ST_IGNORE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state    <= ST_IDLE;
            fsm_q.cnt      <= '0;
            fsm_q.sh       <= '0;
            fsm_q.sect     <= '0;
            fsm_q.is_write <= 1'b0;
            fsm_q.bidx     <= '0;
            fsm_q.miso     <= 1'b0;
            fsm_q.oe       <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign rd_sect = fsm_q.sect;
    assign wr_sect = fsm_q.sect;
    assign wr_bits = fsm_q.sh[1:0];
    assign miso    = fsm_q.miso;
    assign miso_oe = fsm_q.oe;

endmodule

// File: rtl/lock_store.sv
module lock_store #(
    parameter int NUM_SECTORS = 32,
    parameter int SECT_W      = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SECT_W-1:0]      wr_sect,
    input  logic [1:0]             wr_bits,
    input  logic [SECT_W-1:0]      rd_sect,
    output logic [7:0]             rd_byte,
    output logic [NUM_SECTORS-1:0] wr_inhibit,
    output logic [NUM_SECTORS-1:0] lockdown
);

    typedef struct packed {
        logic [NUM_SECTORS-1:0] wl;
        logic [NUM_SECTORS-1:0] ld;
    } store_t;

    store_t store_d, store_q;
    logic [NUM_SECTORS-1:0] wl_nx, ld_nx;

    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sect
        logic hit;
        // a set lock-down bit blocks every later update of this sector
        assign hit      = wr_en && (wr_sect == SECT_W'(s)) && !store_q.ld[s];
        assign wl_nx[s] = hit ? wr_bits[0] : store_q.wl[s];
        assign ld_nx[s] = hit ? wr_bits[1] : store_q.ld[s];
    end

    always_comb begin
        store_d    = store_q;
        store_d.wl = wl_nx;
        store_d.ld = ld_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q.wl <= '0;
            store_q.ld <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign rd_byte    = {6'b0, store_q.ld[rd_sect], store_q.wl[rd_sect]};
    assign wr_inhibit = store_q.wl;
    assign lockdown   = store_q.ld;

endmodule

// File: rtl/spi_lock_reg.sv
module spi_lock_reg #(
    parameter int NUM_SECTORS     = 32,
    parameter int SECTOR_ADDR_LSB = 16,
    parameter int ADDR_BITS       = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_cs_n,
    input  logic                   spi_sck,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   spi_miso_oe,
    input  logic                   write_enable_latch,
    input  logic                   pe_busy,
    output logic [NUM_SECTORS-1:0] sector_wr_inhibit
);

    localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;

    logic                   sck_rise, sck_fall, cs_rise;
    logic [SECT_W-1:0]      rd_sect, wr_sect;
    logic                   wr_en;
    logic [1:0]             wr_bits;
    logic [7:0]             rd_byte;
    logic [NUM_SECTORS-1:0] lockdown_vec;

    spi_pin_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (spi_cs_n),
        .sck      (spi_sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    lock_cmd_fsm #(
        .ADDR_BITS       (ADDR_BITS),
        .SECTOR_ADDR_LSB (SECTOR_ADDR_LSB),
        .SECT_W          (SECT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise),
        .busy     (pe_busy),
        .wel      (write_enable_latch),
        .rd_byte  (rd_byte),
        .rd_sect  (rd_sect),
        .wr_en    (wr_en),
        .wr_sect  (wr_sect),
        .wr_bits  (wr_bits),
        .miso     (spi_miso),
        .miso_oe  (spi_miso_oe)
    );

    lock_store #(
        .NUM_SECTORS (NUM_SECTORS),
        .SECT_W      (SECT_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sect    (wr_sect),
        .wr_bits    (wr_bits),
        .rd_sect    (rd_sect),
        .rd_byte    (rd_byte),
        .wr_inhibit (sector_wr_inhibit),
        .lockdown   (lockdown_vec)
    );

endmodule

// File: rtl/spi_lock_reg_chk.sv
module spi_lock_reg_chk #(
    parameter int NUM_SECTORS = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   spi_cs_n,
    input logic                   pe_busy,
    input logic                   spi_miso,
    input logic                   spi_miso_oe,
    input logic [NUM_SECTORS-1:0] inhibit,
    input logic [NUM_SECTORS-1:0] lockdown,
    input logic [7:0]             rd_byte,
    input logic                   sck_fall
);

    // R1: leaving reset, nothing is locked and the output is released
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (inhibit == '0 && lockdown == '0 && !spi_miso_oe));

    // R3: output data only moves on a detected falling serial clock edge
    p_miso_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && !$past(sck_fall)) |-> $stable(spi_miso));

    // R4: reserved bits of the selected byte are zero
    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_byte[7:2] == 6'b0);

    // R5: deselect releases the output on the next cycle
    p_oe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> !spi_miso_oe);

    // R8: lock-down bits never clear while out of reset
    p_lockdown_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lockdown & $past(lockdown)) == $past(lockdown)));

    // R8: a locked-down sector keeps its write-lock bit
    p_frozen_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((inhibit ^ $past(inhibit)) & $past(lockdown)) == '0));

    // R9: no lock bit changes as a result of a busy cycle
    p_busy_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pe_busy |=> ($stable(inhibit) && $stable(lockdown)));

endmodule

bind spi_lock_reg spi_lock_reg_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .pe_busy     (pe_busy),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .inhibit     (sector_wr_inhibit),
    .lockdown    (lockdown_vec),
    .rd_byte     (rd_byte),
    .sck_fall    (sck_fall)
);

// File: tb/sim_spi_lock_reg.sv
`timescale 1ns/1ps
module sim_spi_lock_reg;

    localparam int NS = 32;
    localparam int HP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic wel = 1'b1, busy = 1'b0;
    logic miso, oe;
    logic [NS-1:0] inh;

    int nchk = 0;
    int nfail = 0;
    logic [1:0] mlock [NS];

    always #5 clk = ~clk;

    spi_lock_reg u0 (
        .clk                (clk),
        .rst_n              (rst_n),
        .spi_cs_n           (cs_n),
        .spi_sck            (sck),
        .spi_mosi           (mosi),
        .spi_miso           (miso),
        .spi_miso_oe        (oe),
        .write_enable_latch (wel),
        .pe_busy            (busy),
        .sector_wr_inhibit  (inh)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] exp_inh();
        logic [NS-1:0] v;
        for (int s = 0; s < NS; s++) v[s] = mlock[s][0];
        return v;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [23:0] a);
        return {6'b0, mlock[a[20:16]]};
    endfunction

    task automatic model_write(input logic [23:0] a, input logic [7:0] d, input int nb,
                               input logic w, input logic b);
        if (nb == 8 && w && !b && !mlock[a[20:16]][1]) mlock[a[20:16]] = d[1:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NS; s++) mlock[s] = 2'b00;
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input logic b, output logic o, output logic e);
        mosi = b;
        repeat (HP) @(negedge clk);
        o = miso; e = oe;
        sck = 1'b1;
        repeat (HP) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic cs_begin(input bit m3);
        @(negedge clk);
        if (m3) begin
            sck = 1'b1;
            repeat (HP) @(negedge clk);
        end
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        if (m3) begin
            sck = 1'b0;
            repeat (HP) @(negedge clk);
        end
    endtask

    task automatic cs_end(input bit m3);
        repeat (HP) @(negedge clk);
        if (m3) begin
            sck = 1'b1;
            repeat (HP) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (2 * HP) @(negedge clk);
        sck = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic rd_cmd(input logic [23:0] a, input int nbits, input bit m3,
                          output logic [15:0] got, output logic hdr_oe,
                          output logic all_oe, output logic any_oe);
        logic o, e;
        logic [31:0] hdr;
        hdr = {8'hE8, a};
        got = '0; hdr_oe = 1'b0; all_oe = 1'b1; any_oe = 1'b0;
        cs_begin(m3);
        for (int i = 31; i >= 0; i--) begin
            xfer(hdr[i], o, e);
            hdr_oe |= e;
        end
        for (int i = 0; i < nbits; i++) begin
            xfer(1'b0, o, e);
            got = {got[14:0], o};
            all_oe &= e;
            any_oe |= e;
        end
        cs_end(m3);
    endtask

    task automatic wr_cmd(input logic [23:0] a, input logic [7:0] d, input int nb);
        logic o, e;
        logic [31:0] hdr;
        hdr = {8'hE5, a};
        cs_begin(1'b0);
        for (int i = 31; i >= 0; i--) xfer(hdr[i], o, e);
        for (int i = 0; i < nb; i++) xfer((i < 8) ? d[7-i] : 1'b0, o, e);
        cs_end(1'b0);
    endtask

    task automatic read_expect(input logic [23:0] a, input string req);
        logic [15:0] got;
        logic h, al, an;
        rd_cmd(a, 8, 1'b0, got, h, al, an);
        check(got[7:0] == exp_byte(a), req, {24'h0, got[7:0]}, {24'h0, exp_byte(a)});
        check(!h && al, {req, " R5 oe window"}, {30'h0, h, al}, 32'h1);
        check(!oe, {req, " R5 oe after deselect"}, {31'h0, oe}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [15:0] got;
        logic h, al, an, o, e;
        logic [31:0] hdr;
        void'($urandom(32'd20240611));
        do_reset();

        // R1: reset state
        check(!oe, "R1 oe", {31'h0, oe}, 32'h0);
        check(inh == '0, "R1 inhibit", inh, 32'h0);
        read_expect(24'h00_0000, "R1 sector0");
        read_expect(24'h1F_8000, "R1 sector31");

        // R2 R7: high address bits ignored, inhibit follows bit0
        wr_cmd(24'hE3_1234, 8'h01, 8); model_write(24'h03_0000, 8'h01, 8, 1, 0);
        check(inh == exp_inh(), "R7 inhibit after write", inh, exp_inh());
        check(inh[3] == 1'b1, "R2 sector3 via high bits", {31'h0, inh[3]}, 32'h1);
        read_expect(24'h03_FFFF, "R2 alias read sector3");
        read_expect(24'h1F_0000, "R2 sector31 untouched");

        // R6: partial bytes and disabled latch do nothing
        wr_cmd(24'h05_0000, 8'h01, 7);
        check(inh[5] == 1'b0, "R6 seven bits", {31'h0, inh[5]}, 32'h0);
        wr_cmd(24'h05_0000, 8'h01, 9);
        check(inh[5] == 1'b0, "R6 nine bits", {31'h0, inh[5]}, 32'h0);
        wel = 1'b0;
        wr_cmd(24'h05_0000, 8'h01, 8);
        check(inh[5] == 1'b0, "R6 latch clear", {31'h0, inh[5]}, 32'h0);
        wel = 1'b1;

        // R4: reserved bits read zero
        wr_cmd(24'h06_0000, 8'hFC, 8); model_write(24'h06_0000, 8'hFC, 8, 1, 0);
        read_expect(24'h06_0000, "R4 reserved only");
        wr_cmd(24'h06_0000, 8'hFD, 8); model_write(24'h06_0000, 8'hFD, 8, 1, 0);
        read_expect(24'h06_0000, "R4 reserved plus bit0");

        // R8: lock-down freezes both bits
        wr_cmd(24'h07_0000, 8'h03, 8); model_write(24'h07_0000, 8'h03, 8, 1, 0);
        read_expect(24'h07_0000, "R8 locked down");
        wr_cmd(24'h07_0000, 8'h00, 8);
        read_expect(24'h07_0000, "R8 clear attempt");
        check(inh[7] == 1'b1, "R8 inhibit held", {31'h0, inh[7]}, 32'h1);

        // R9: busy rejects commands
        busy = 1'b1;
        rd_cmd(24'h07_0000, 8, 1'b0, got, h, al, an);
        check(!an, "R9 read while busy", {31'h0, an}, 32'h0);
        wr_cmd(24'h08_0000, 8'h01, 8);
        busy = 1'b0;
        check(inh[8] == 1'b0, "R9 write while busy", {31'h0, inh[8]}, 32'h0);

        // R3: repeated byte and idle-high clock
        rd_cmd(24'h07_1111, 16, 1'b0, got, h, al, an);
        check(got == 16'h0303, "R3 repeat byte", {16'h0, got}, 32'h0303);
        rd_cmd(24'h03_2222, 8, 1'b1, got, h, al, an);
        check(got[7:0] == 8'h01, "R3 clock idle high", {24'h0, got[7:0]}, 32'h01);

        // R10: unknown opcode then a write pattern in the same select
        hdr = {8'h9F, 24'h0A_0000};
        an = 1'b0;
        cs_begin(1'b0);
        for (int i = 31; i >= 0; i--) begin xfer(hdr[i], o, e); an |= e; end
        hdr = {8'hE5, 24'h0A_0000};
        for (int i = 31; i >= 0; i--) begin xfer(hdr[i], o, e); an |= e; end
        for (int i = 0; i < 8; i++) begin xfer((i == 7), o, e); an |= e; end
        cs_end(1'b0);
        check(!an, "R10 no output", {31'h0, an}, 32'h0);
        check(inh[10] == 1'b0, "R10 no write", {31'h0, inh[10]}, 32'h0);
        read_expect(24'h03_0000, "R10 next command");

        // R11: early deselect in the data phase
        rd_cmd(24'h07_0000, 3, 1'b0, got, h, al, an);
        check(got[2:0] == 3'b000 && !oe, "R11 early end", {28'h0, oe, got[2:0]}, 32'h0);
        read_expect(24'h07_0000, "R11 next command");

        // R1 R8: reset clears lock-down
        do_reset();
        check(inh == '0, "R8 reset clears", inh, 32'h0);
        read_expect(24'h07_0000, "R8 reset clears lock-down");

        // random mix
        for (int it = 0; it < 220; it++) begin
            logic [23:0] a;
            logic [7:0] d;
            int nb;
            logic w, b;
            if (it % 50 == 49) do_reset();
            a = 24'($urandom());
            d = 8'($urandom());
            d[1] = ($urandom_range(0, 7) == 0);
            nb = ($urandom_range(0, 7) == 0) ? (($urandom_range(0, 1) == 0) ? 7 : 9) : 8;
            w = ($urandom_range(0, 5) != 0);
            b = ($urandom_range(0, 7) == 0);
            wel = w; busy = b;
            if ($urandom_range(0, 1) == 0) begin
                wr_cmd(a, d, nb);
                model_write(a, d, nb, w, b);
                check(inh == exp_inh(), "R6 R8 R9 random write", inh, exp_inh());
            end else if (b) begin
                rd_cmd(a, 8, 1'b0, got, h, al, an);
                check(!an, "R9 random busy read", {31'h0, an}, 32'h0);
            end else begin
                busy = 1'b0;
                read_expect(a, "R3 random read");
            end
            busy = 1'b0; wel = 1'b1;
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule